// File: doc/BRIEF.md
# Decrement-and-Compare Memory Sequencer

This block runs, cycle by cycle, the bus side of a combined "decrement memory, then compare the accumulator with the result" operation. It targets an 8-bit CPU core with a 16-bit address space. The core's fetch unit presents the addressing mode, the one or two operand bytes and the A, X and Y register values. It then pulses `start_i` in the opcode-fetch cycle. The sequencer resolves the effective address, reads the operand and writes the unmodified byte back. In the following cycle it writes the byte minus one. From that cycle it also sets the N, Z and C flags as a compare of A against the decremented byte.

Seven addressing modes are supported, including pre-indexed and post-indexed indirect through page zero. These two indirect forms run for eight cycles. The memory bus is a plain synchronous one. An address is driven during a cycle, read data comes back within that same cycle, and a write is taken at the clock edge that ends a cycle in which `mem_we_o` is high. The cycles used by each instruction are reported on `cycle_count_o`, counting the opcode-fetch cycle as cycle 1.

Top module: `dec_cmp_seq`

## Requirements
- R1: The last two cycles of an instruction are writes to the effective address: first the byte as read, then the byte minus one modulo 256 (0x00 becomes 0xFF).
- R2: At completion, C is 1 exactly when A, read as unsigned, is greater than or equal to the decremented byte.
- R3: At completion, Z is 1 exactly when the decremented byte equals A. It does not reflect whether the byte reached zero.
- R4: At completion, N equals bit 7 of (A minus decremented byte) modulo 256.
- R5: Mode codes on `mode_i` are 0 zp, 1 zp+X, 2 abs, 3 abs+X, 4 abs+Y, 5 (zp+X) indirect, 6 (zp) indirect then +Y. They take 5, 6, 6, 7, 7, 8 and 8 cycles, counting the start cycle as 1. The (zp),Y mode always spends one fix-up cycle, whether or not a page is crossed.
- R6: The effective address is {00,lo} for zp. For zp+X it is {00,(lo+X) mod 256}. For abs it is {hi,lo}. For abs+X and abs+Y it is {hi,lo} plus the index, as a full 16-bit sum.
- R7: For mode 5 the pointer is (lo+X) mod 256. For mode 6 the pointer is lo, and the result is then offset by Y with a 16-bit add. In both modes the pointer's high byte is read from (pointer+1) mod 256, so it wraps within page zero.
- R8: `done_o` is high for exactly one clock, in the decremented-write cycle. `cycle_count_o` equals the cycle count in that cycle and holds it until the next start.
- R9: A start with mode code 7 (immediate, unsupported) is ignored: the block stays idle and issues no write.
- R10: `start_i` is ignored while an instruction is in progress.
- R11: After reset the block is idle with `done_o`, `mem_we_o`, all flags and `cycle_count_o` at zero.
- R12: The mode, the operand bytes and A, X, Y are sampled in the start cycle. Later changes to these inputs do not affect the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an instruction (opcode-fetch cycle) |
| mode_i | input | 3 | Addressing mode code |
| op_lo_i | input | 8 | First operand byte |
| op_hi_i | input | 8 | Second operand byte |
| a_i | input | 8 | Accumulator |
| x_i | input | 8 | X index |
| y_i | input | 8 | Y index |
| mem_addr_o | output | 16 | Bus address |
| mem_rdata_i | input | 8 | Read data for the current address |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Write enable |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Final write cycle |
| cycle_count_o | output | 4 | Cycles used by the current or last instruction |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
The memory model returns a position-dependent pattern mixed with a per-instruction salt. A wrong pointer byte or a wrong effective address therefore shows up as a wrong write address or wrong data. Random instructions over all seven modes, with random A, X, Y and operands, cover page crossings and wraps at random. Directed cases add further boundaries:
- A byte of 0x00, which tells a modulo decrement from a saturating one.
- A equal to the decremented byte, which tells a compare against the result from a compare against the original byte or against zero.
- Pointers at 0xFF, which tell a page-zero wrap from a 16-bit carry.
- An abs+X page crossing.
- Mode 7.
- A start held high through an instruction, which tells an ignored start from a restart.
- Operand inputs changed after the start cycle.

// File: rtl/dec_cmp_pkg.sv
package dec_cmp_pkg;
  parameter int unsigned DW    = 8;
  parameter int unsigned AW    = 16;
  parameter int unsigned CNT_W = 4;

  typedef enum logic [2:0] {
    M_ZP   = 3'd0,
    M_ZPX  = 3'd1,
    M_ABS  = 3'd2,
    M_ABSX = 3'd3,
    M_ABSY = 3'd4,
    M_INDX = 3'd5,
    M_INDY = 3'd6,
    M_IMM  = 3'd7
  } mode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_OPND1, S_OPND2, S_IDX, S_PLO, S_PHI, S_FIX, S_READ, S_WB, S_WDEC
  } st_e;

  function automatic logic [CNT_W-1:0] mode_cycles(input mode_e m);
    case (m)
      M_ZP:           mode_cycles = CNT_W'(5);
      M_ZPX, M_ABS:   mode_cycles = CNT_W'(6);
      M_ABSX, M_ABSY: mode_cycles = CNT_W'(7);
      M_INDX, M_INDY: mode_cycles = CNT_W'(8);
      default:        mode_cycles = '0;
    endcase
  endfunction
endpackage

// File: rtl/dec_cmp_alu.sv
module dec_cmp_alu
  import dec_cmp_pkg::*;
(
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  output logic [DW-1:0] dec_o,
  output logic          n_o,
  output logic          z_o,
  output logic          c_o
);
  logic [DW:0] diff;

  always_comb begin
    dec_o = opnd_i - DW'(1);
    diff  = {1'b0, acc_i} - {1'b0, dec_o};
    c_o   = ~diff[DW];          // no borrow: acc >= dec
    z_o   = (diff[DW-1:0] == '0);
    n_o   = diff[DW-1];
  end
endmodule

// File: rtl/dec_cmp_ctrl.sv
module dec_cmp_ctrl
  import dec_cmp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       mode_i,
  input  logic [DW-1:0]    op_lo_i,
  input  logic [DW-1:0]    op_hi_i,
  input  logic [DW-1:0]    x_i,
  input  logic [DW-1:0]    y_i,
  input  logic [DW-1:0]    rdata_i,
  input  logic [DW-1:0]    dec_i,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    wdata_o,
  output logic             we_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             go_o,
  output logic [DW-1:0]    opnd_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned PW = AW - DW;

  st_e                st_q, st_d;
  mode_e              mode_q;
  logic [DW-1:0]      lo_q, hi_q, x_q, y_q, ptr_q, opnd_q;
  logic [AW-1:0]      ea_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [DW-1:0]      idx, zp_sum, ptr_inc, fix_lo;
  logic               go;

  assign go      = start_i && (st_q == S_IDLE) && (mode_e'(mode_i) != M_IMM);
  assign idx     = (mode_q == M_ABSY || mode_q == M_INDY) ? y_q : x_q;
  assign zp_sum  = lo_q + x_q;
  assign ptr_inc = ptr_q + DW'(1);
  assign fix_lo  = ea_q[DW-1:0] + idx;

  always_comb begin
    st_d    = st_q;
    addr_o  = ea_q;
    we_o    = 1'b0;
    wdata_o = opnd_q;
    done_o  = 1'b0;
    case (st_q)
      S_IDLE: begin
        addr_o = '0;
        if (go) st_d = S_OPND1;
      end
      S_OPND1: begin
        addr_o = '0;
        case (mode_q)
          M_ZP:                  st_d = S_READ;
          M_ZPX, M_INDX:         st_d = S_IDX;
          M_ABS, M_ABSX, M_ABSY: st_d = S_OPND2;
          M_INDY:                st_d = S_PLO;
          default:               st_d = S_IDLE;
        endcase
      end
      S_OPND2: begin
        addr_o = '0;
        st_d   = (mode_q == M_ABS) ? S_READ : S_FIX;
      end
      S_IDX: begin
        addr_o = {PW'(0), lo_q};       // dummy read while indexing
        st_d   = (mode_q == M_INDX) ? S_PLO : S_READ;
      end
      S_PLO: begin
        addr_o = {PW'(0), ptr_q};
        st_d   = S_PHI;
      end
      S_PHI: begin
        addr_o = {PW'(0), ptr_inc};
        st_d   = (mode_q == M_INDX) ? S_READ : S_FIX;
      end
      S_FIX: begin
        addr_o = {ea_q[AW-1:DW], fix_lo};  // read before high-byte carry
        st_d   = S_READ;
      end
      S_READ: st_d = S_WB;
      S_WB: begin
        we_o = 1'b1;
        st_d = S_WDEC;
      end
      S_WDEC: begin
        we_o    = 1'b1;
        wdata_o = dec_i;
        done_o  = 1'b1;
        st_d    = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      mode_q <= M_ZP;
      lo_q   <= '0;
      hi_q   <= '0;
      x_q    <= '0;
      y_q    <= '0;
      ptr_q  <= '0;
      ea_q   <= '0;
      opnd_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q <= st_d;
      if (go) begin
        mode_q <= mode_e'(mode_i);
        lo_q   <= op_lo_i;
        hi_q   <= op_hi_i;
        x_q    <= x_i;
        y_q    <= y_i;
        cnt_q  <= CNT_W'(2);
      end else if (st_q != S_IDLE && st_q != S_WDEC) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      case (st_q)
        S_OPND1: begin
          ea_q  <= {PW'(0), lo_q};
          ptr_q <= lo_q;
        end
        S_OPND2: ea_q <= {hi_q, lo_q};
        S_IDX: begin
          ea_q  <= {PW'(0), zp_sum};
          ptr_q <= zp_sum;
        end
        S_PLO:  ea_q[DW-1:0]  <= rdata_i;
        S_PHI:  ea_q[AW-1:DW] <= rdata_i;
        S_FIX:  ea_q <= ea_q + {PW'(0), idx};
        S_READ: opnd_q <= rdata_i;
        default: ;
      endcase
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign go_o   = go;
  assign opnd_o = opnd_q;
  assign cnt_o  = cnt_q;

  // R5: cycle count at completion matches the latched mode
  p_cycles_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cnt_q == mode_cycles(mode_q));
  // R7: pointer and zero-page index accesses stay in page zero
  p_zp_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDX || st_q == S_PLO || st_q == S_PHI) |-> addr_o[AW-1:DW] == '0);
  // R10: no restart while an instruction runs
  p_no_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/dec_cmp_seq.sv
module dec_cmp_seq
  import dec_cmp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       mode_i,
  input  logic [DW-1:0]    op_lo_i,
  input  logic [DW-1:0]    op_hi_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    x_i,
  input  logic [DW-1:0]    y_i,
  output logic [AW-1:0]    mem_addr_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic [DW-1:0]    mem_wdata_o,
  output logic             mem_we_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cycle_count_o,
  output logic             flag_n_o,
  output logic             flag_z_o,
  output logic             flag_c_o
);
  logic [DW-1:0] acc_q, opnd, dec;
  logic          go, n_d, z_d, c_d;
  logic          n_q, z_q, c_q;

  dec_cmp_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .mode_i  (mode_i),
    .op_lo_i (op_lo_i),
    .op_hi_i (op_hi_i),
    .x_i     (x_i),
    .y_i     (y_i),
    .rdata_i (mem_rdata_i),
    .dec_i   (dec),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o),
    .we_o    (mem_we_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .go_o    (go),
    .opnd_o  (opnd),
    .cnt_o   (cycle_count_o)
  );

  dec_cmp_alu u_alu (
    .acc_i  (acc_q),
    .opnd_i (opnd),
    .dec_o  (dec),
    .n_o    (n_d),
    .z_o    (z_d),
    .c_o    (c_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
      c_q   <= 1'b0;
    end else begin
      if (go) acc_q <= a_i;
      if (done_o) begin
        n_q <= n_d;
        z_q <= z_d;
        c_q <= c_d;
      end
    end
  end

  assign flag_n_o = n_q;
  assign flag_z_o = z_q;
  assign flag_c_o = c_q;

  // R1: write-back pair at one address, second byte one less
  p_write_pair_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !done_o) |=> mem_we_o && done_o && $stable(mem_addr_o)
      && mem_wdata_o == $past(mem_wdata_o) - DW'(1));
  // R8: done lasts one clock
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  // R3: Z tracks equality of A and the written decremented byte
  p_zero_eq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> flag_z_o == (acc_q == $past(mem_wdata_o)));
  // R9: unsupported mode never leaves idle
  p_imm_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && mode_i == 3'd7) |=> !busy_o);
endmodule

// File: tb/sim_dec_cmp_seq.sv
module sim_dec_cmp_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [7:0]  op_lo_i = '0, op_hi_i = '0, a_i = '0, x_i = '0, y_i = '0;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_rdata_i, mem_wdata_o;
  logic        mem_we_o, busy_o, done_o, flag_n_o, flag_z_o, flag_c_o;
  logic [3:0]  cycle_count_o;
  logic [7:0]  salt = 8'h00;
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  function automatic logic [7:0] mem_fn(input logic [15:0] a, input logic [7:0] s);
    return (a[7:0] * 8'd7) ^ {a[10:8], a[15:11]} ^ s;
  endfunction

  assign mem_rdata_i = mem_fn(mem_addr_o, salt);

  dec_cmp_seq u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_cycles(input logic [2:0] m);
    case (m)
      3'd0: return 5;
      3'd1, 3'd2: return 6;
      3'd3, 3'd4: return 7;
      default: return 8;
    endcase
  endfunction

  function automatic logic [15:0] exp_ea(input logic [2:0] m, input logic [7:0] lo, hi, x, y,
                                         input logic [7:0] s);
    logic [7:0] p;
    case (m)
      3'd0: return {8'h00, lo};
      3'd1: return {8'h00, 8'(lo + x)};
      3'd2: return {hi, lo};
      3'd3: return {hi, lo} + {8'h00, x};
      3'd4: return {hi, lo} + {8'h00, y};
      3'd5: begin
        p = lo + x;
        return {mem_fn({8'h00, 8'(p + 8'd1)}, s), mem_fn({8'h00, p}, s)};
      end
      default: begin
        p = lo;
        return {mem_fn({8'h00, 8'(p + 8'd1)}, s), mem_fn({8'h00, p}, s)} + {8'h00, y};
      end
    endcase
  endfunction

  task automatic run(input logic [2:0] m, input logic [7:0] lo, hi, a, x, y, input bit hold);
    logic [15:0] ea, w0a, w1a;
    logic [7:0]  d, dec, w0d, w1d, diff;
    int          k, dk, wcnt, cc, ec;
    bit          seen;
    ea = exp_ea(m, lo, hi, x, y, salt);
    d = mem_fn(ea, salt);
    dec = d - 8'd1;
    diff = a - dec;
    ec = exp_cycles(m);
    @(negedge clk_i);
    start_i = 1'b1; mode_i = m; op_lo_i = lo; op_hi_i = hi; a_i = a; x_i = x; y_i = y;
    @(negedge clk_i);
    if (!hold) start_i = 1'b0;
    // R12: scramble inputs after the start cycle
    mode_i = 3'($urandom_range(0, 6)); op_lo_i = 8'($urandom); op_hi_i = 8'($urandom);
    a_i = 8'($urandom); x_i = 8'($urandom); y_i = 8'($urandom);
    k = 2; seen = 0; wcnt = 0; dk = 0; cc = 0;
    w0a = '0; w1a = '0; w0d = '0; w1d = '0;
    while (k <= 12 && !seen) begin
      if (mem_we_o) begin
        if (wcnt == 0) begin w0a = mem_addr_o; w0d = mem_wdata_o; end
        else begin w1a = mem_addr_o; w1d = mem_wdata_o; end
        wcnt++;
      end
      if (done_o) begin seen = 1; dk = k; cc = int'(cycle_count_o); end
      else begin @(negedge clk_i); k++; end
    end
    start_i = 1'b0;
    chk(seen && dk == ec, "R5 cycles", dk, ec);
    chk(cc == ec, "R8 count at done", cc, ec);
    chk(wcnt == 2, "R1 write count", wcnt, 2);
    chk(w0a == ea && w1a == ea, "R6/R7 effective address", int'(w1a), int'(ea));
    chk(w0d == d, "R1 first write", w0d, d);
    chk(w1d == dec, "R1 decremented write", w1d, dec);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R8 done pulse / R10 no restart", {done_o, busy_o}, 0);
    chk(int'(cycle_count_o) == ec, "R8 count held", cycle_count_o, ec);
    chk(flag_c_o == (a >= dec), "R2 carry", flag_c_o, (a >= dec));
    chk(flag_z_o == (a == dec), "R3 zero", flag_z_o, (a == dec));
    chk(flag_n_o == diff[7], "R4 negative", flag_n_o, diff[7]);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    // R11: reset state
    chk(!busy_o && !done_o && !mem_we_o, "R11 idle outputs", {busy_o, done_o, mem_we_o}, 0);
    chk({flag_n_o, flag_z_o, flag_c_o} == 3'b000, "R11 flags", {flag_n_o, flag_z_o, flag_c_o}, 0);
    chk(cycle_count_o == 4'd0, "R11 count", cycle_count_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: byte 0x00 decrements to 0xFF (zp address with value 0 under salt)
    salt = mem_fn(16'h0010, 8'h00);
    run(3'd0, 8'h10, 8'h00, 8'hFF, 8'h00, 8'h00, 0);
    // R3: A equal to decremented value
    salt = 8'h3C;
    run(3'd2, 8'h34, 8'h12, mem_fn(16'h1234, 8'h3C) - 8'd1, 8'h00, 8'h00, 0);
    // R3: byte 0x01 decrements to zero, A nonzero -> Z clear
    salt = mem_fn(16'h0020, 8'h00) ^ 8'h01;
    run(3'd0, 8'h20, 8'h00, 8'h80, 8'h00, 8'h00, 0);
    // R6: zp+X wraps within page zero
    salt = 8'h11;
    run(3'd1, 8'hF0, 8'h77, 8'h40, 8'h20, 8'h00, 0);
    // R6: abs+X page crossing
    salt = 8'h22;
    run(3'd3, 8'hF8, 8'h30, 8'h00, 8'h10, 8'h00, 0);
    // R7: pointer at 0xFF wraps for both indirect modes
    salt = 8'h33;
    run(3'd5, 8'hF0, 8'h00, 8'h55, 8'h0F, 8'h00, 0);
    run(3'd6, 8'hFF, 8'h00, 8'hAA, 8'h00, 8'hC0, 0);
    // R10: start held high through an instruction
    salt = 8'h44;
    run(3'd6, 8'h08, 8'h00, 8'h12, 8'h00, 8'h01, 1);

    // R9: mode 7 ignored
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 3'd7;
    @(negedge clk_i);
    start_i = 1'b0;
    begin
      bit any_we = 0, any_busy = 0;
      for (int i = 0; i < 4; i++) begin
        any_we |= mem_we_o; any_busy |= busy_o;
        @(negedge clk_i);
      end
      chk(!any_we && !any_busy, "R9 immediate ignored", {any_we, any_busy}, 0);
    end

    // R5/R6/R12: random mix
    for (int n = 0; n < 150; n++) begin
      salt = 8'($urandom);
      run(3'($urandom_range(0, 6)), 8'($urandom), 8'($urandom), 8'($urandom),
          8'($urandom), 8'($urandom), 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule